// File: doc/BRIEF.md
# Loop Code Pattern Transmitter

This block sits on the transmit side of a T1 serial path, just ahead of the line driver. In normal operation it forwards the outgoing payload bit stream one bit per strobe. When a far-end loop activation or release is wanted, control logic raises one of two request bits. The block then overwrites the stream with a short repeating code, one bit per strobe, until the request drops.

Each code is supplied as an 8-bit left-aligned field with a 2-bit length selector, so codes of 5 to 8 bits can be sent. The usual activation pattern 00001 fits directly. The usual release pattern 001 is sent by programming it twice (001001) with a 6-bit length. A mode bit chooses between two insertion styles. In framed insertion, positions that the upstream framer marks as framing bits carry the incoming data unchanged and the code pauses. In unframed insertion, every bit position carries the code. Framing generation is done upstream.

Top module: `loop_code_tx`

## Requirements
- R1: While rst_n is low at a clock edge, tx_bit is forced to 0.
- R2: With neither up_req nor dn_req set, each strobe (bit_en high at a clock edge) loads tx_bit with that cycle's data_in.
- R3: tx_bit changes only at clock edges where bit_en is high.
- R4: With up_req set, successive strobes send up_code from bit 7 downward, repeating with a period of 5 plus up_len bits.
- R5: With dn_req set and up_req clear, successive strobes send dn_code in the same way, with period 5 plus dn_len bits.
- R6: With both requests set, the up code is sent.
- R7: The length field value 0, 1, 2 or 3 selects 5, 6, 7 or 8 bits. Code bits below the selected length are never sent.
- R8: The first code strobe after a request rises, or after the selected code switches between up and down, sends bit 7 of the newly selected code.
- R9: With frame_mode set, a strobe with frame_mark high sends data_in, and the code position does not advance on that strobe.
- R10: With frame_mode clear, frame_mark is ignored and the code occupies every bit position.
- R11: When both requests drop, the next strobe sends data_in again.
- R12: Programmed as 8'b00001000 with length 0, the up code sends 00001 repeatedly. Programmed as 8'b00100100 with length 1, the down code sends 001 repeatedly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit strobe; one serial bit per high cycle |
| data_in | input | 1 | Outgoing payload bit |
| frame_mark | input | 1 | Marks data_in as a framing bit |
| frame_mode | input | 1 | 1 = framed insertion, 0 = unframed |
| up_req | input | 1 | Request sending of the activation code |
| dn_req | input | 1 | Request sending of the release code |
| up_code | input | 8 | Activation code, left-aligned, MSB sent first |
| up_len | input | 2 | Activation code length select (5 + value bits) |
| dn_code | input | 8 | Release code, left-aligned, MSB sent first |
| dn_len | input | 2 | Release code length select (5 + value bits) |
| tx_bit | output | 1 | Registered serial output |

## Verification
The bench builds the block with its default parameters: an 8-bit code field, a 2-bit length field and a minimum length of 5. With these values all four lengths from 5 to the full field width can be reached, including the case where the pointer wraps at the top bit of the field. Codes are chosen with distinct low bits so that any truncation or overrun error shows at the port. Framing marks are placed at intervals that do not divide the code length, so that a pointer that advances on framing bits shifts the expected pattern.

// File: rtl/lct_pkg.sv
// Package: shared constants and types for the loop code transmitter.
// Assumes: codes are left-aligned in CODE_W bits; the longest code
// (LEN_MIN + 2**LEN_W - 1) fits inside CODE_W.
package lct_pkg;

    localparam int unsigned CODE_W  = 8;
    localparam int unsigned LEN_W   = 2;
    localparam int unsigned LEN_MIN = 5;

    // Which code, if any, is on the line
    typedef enum logic [1:0] {
        LC_IDLE = 2'd0,
        LC_UP   = 2'd1,
        LC_DN   = 2'd2
    } lc_mode_e;

endpackage

// File: rtl/lct_code_sel.sv
// Module: lct_code_sel
// Chooses which code is active from the two request bits. The up code
// wins when both are set. Also turns the length field into the index
// of the last code bit.
// Assumes: purely combinational; inputs come straight from the control
// registers and are stable between strobes.
module lct_code_sel
    import lct_pkg::*;
#(
    parameter int unsigned CW    = CODE_W,
    parameter int unsigned LW    = LEN_W,
    parameter int unsigned LMIN  = LEN_MIN,
    localparam int unsigned PW   = $clog2(CW)
) (
    input  logic          up_req,
    input  logic          dn_req,
    input  logic [CW-1:0] up_code,
    input  logic [LW-1:0] up_len,
    input  logic [CW-1:0] dn_code,
    input  logic [LW-1:0] dn_len,
    output lc_mode_e      mode,
    output logic [CW-1:0] code,
    output logic [PW-1:0] last_idx
);

    logic [LW-1:0] len_sel;

    // Priority pick: the up request masks the down request
    always_comb begin
        if (up_req) begin
            mode    = LC_UP;
            code    = up_code;
            len_sel = up_len;
        end else if (dn_req) begin
            mode    = LC_DN;
            code    = dn_code;
            len_sel = dn_len;
        end else begin
            mode    = LC_IDLE;
            code    = '0;
            len_sel = '0;
        end
    end

    // Index of the final bit sent in one period of the code
    always_comb begin
        last_idx = PW'(LMIN - 1) + PW'(len_sel);
    end

    // Elaboration-time check that the longest code fits in the field
    initial begin
        a_r7_len_fits: assert (LMIN + (1 << LW) - 1 <= CW)
            else $error("longest code exceeds the code field width");
    end

endmodule

// File: rtl/lct_pattern_ptr.sv
// Module: lct_pattern_ptr
// Tracks the position inside the active code. The position restarts at
// the first bit whenever the selected code changes, wraps after the
// last bit, and freezes on framing bits when asked to hold.
// Assumes: advances only when bit_en is high; last_idx < 2**PW.
module lct_pattern_ptr
    import lct_pkg::*;
#(
    parameter int unsigned CW  = CODE_W,
    localparam int unsigned PW = $clog2(CW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  lc_mode_e      mode,
    input  logic [PW-1:0] last_idx,
    input  logic          hold,
    output logic [PW-1:0] pos,
    output logic          fresh
);

    logic [PW-1:0] ptr_q;
    lc_mode_e      prev_q;

    // A new or switched code starts from its first bit
    always_comb begin
        fresh = (mode != prev_q);
    end

    // Position used this strobe; out-of-range pointers fall back to zero
    always_comb begin
        if (fresh || (ptr_q > last_idx)) pos = '0;
        else                             pos = ptr_q;
    end

    // Pointer and last-mode registers, updated once per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            prev_q <= LC_IDLE;
        end else if (bit_en) begin
            prev_q <= mode;
            if (mode == LC_IDLE)      ptr_q <= '0;
            else if (hold)            ptr_q <= pos;
            else if (pos == last_idx) ptr_q <= '0;
            else                      ptr_q <= pos + 1'b1;
        end
    end

    // R9: a framing bit inside a running code leaves the pointer alone
    a_r9_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && hold && mode != LC_IDLE && mode == prev_q && ptr_q <= last_idx)
        |=> (ptr_q == $past(ptr_q)))
        else $error("pointer moved on a framing bit");

    // R8: a fresh code that sends its first bit moves on to the second
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !hold && mode != LC_IDLE && mode != prev_q)
        |=> (ptr_q == PW'(1)))
        else $error("pointer did not restart at the first code bit");

    // R4: pointer never rests beyond the last bit of a running code
    a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && mode != LC_IDLE) |=> (ptr_q <= $past(last_idx)))
        else $error("pointer beyond code length");

endmodule

// File: rtl/lct_out_stage.sv
// Module: lct_out_stage
// Output register: on each strobe, loads either the selected code bit or
// the incoming data bit. Holds its value between strobes.
// Assumes: use_code and code_bit are settled before the clock edge.
module lct_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic use_code,
    input  logic code_bit,
    input  logic data_in,
    output logic tx_bit
);

    // Registered output mux, enabled by the bit strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_bit <= 1'b0;
        else if (bit_en) tx_bit <= use_code ? code_bit : data_in;
    end

    // R3: no strobe, no change
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit))
        else $error("output changed without a strobe");

endmodule

// File: rtl/loop_code_tx.sv
// Module: loop_code_tx (top)
// Overlays a programmable repeating loop code on a T1 transmit bit
// stream, either over every bit or around framing bits.
// Assumes: frame_mark is aligned with data_in; the control inputs come
// from registers in the same clock domain.
module loop_code_tx
    import lct_pkg::*;
#(
    parameter int unsigned CW   = CODE_W,
    parameter int unsigned LW   = LEN_W,
    parameter int unsigned LMIN = LEN_MIN,
    localparam int unsigned PW  = $clog2(CW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          data_in,
    input  logic          frame_mark,
    input  logic          frame_mode,
    input  logic          up_req,
    input  logic          dn_req,
    input  logic [CW-1:0] up_code,
    input  logic [LW-1:0] up_len,
    input  logic [CW-1:0] dn_code,
    input  logic [LW-1:0] dn_len,
    output logic          tx_bit
);

    lc_mode_e      mode;
    logic [CW-1:0] cur_code;
    logic [PW-1:0] last_idx;
    logic [PW-1:0] pos;
    logic          fresh;
    logic          hold;
    logic          use_code;
    logic          code_bit;

    lct_code_sel #(.CW(CW), .LW(LW), .LMIN(LMIN)) u_sel (
        .up_req   (up_req),
        .dn_req   (dn_req),
        .up_code  (up_code),
        .up_len   (up_len),
        .dn_code  (dn_code),
        .dn_len   (dn_len),
        .mode     (mode),
        .code     (cur_code),
        .last_idx (last_idx)
    );

    // Framing positions are protected only in framed mode
    always_comb begin
        hold = frame_mode & frame_mark;
    end

    lct_pattern_ptr #(.CW(CW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .mode     (mode),
        .last_idx (last_idx),
        .hold     (hold),
        .pos      (pos),
        .fresh    (fresh)
    );

    // Code bit at the current position, counted from the MSB
    always_comb begin
        code_bit = cur_code[(CW - 1) - 32'(pos)];
        use_code = (mode != LC_IDLE) && !hold;
    end

    lct_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .use_code (use_code),
        .code_bit (code_bit),
        .data_in  (data_in),
        .tx_bit   (tx_bit)
    );

    // R2: idle strobes forward the payload
    a_r2_pass_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !up_req && !dn_req) |=> (tx_bit == $past(data_in)))
        else $error("idle strobe did not forward data");

    // R9: framing bits pass through in framed mode
    a_r9_frame_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_mode && frame_mark) |=> (tx_bit == $past(data_in)))
        else $error("framing bit overwritten");

    // R8: first strobe of a new code sends its MSB
    a_r8_first_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fresh && (up_req || dn_req) && !hold)
        |=> (tx_bit == $past(cur_code[CW-1])))
        else $error("new code did not start at its MSB");

    // R6: with both requests on a fresh start, the up code MSB goes out
    a_r6_up_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fresh && up_req && dn_req && !hold)
        |=> (tx_bit == $past(up_code[CW-1])))
        else $error("down code sent while up was requested");

endmodule

// File: tb/loop_code_tx_bench.sv
module loop_code_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       data_in;
    logic       frame_mark;
    logic       frame_mode;
    logic       up_req;
    logic       dn_req;
    logic [7:0] up_code;
    logic [1:0] up_len;
    logic [7:0] dn_code;
    logic [1:0] dn_len;
    logic       tx_bit;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    loop_code_tx u_loop_code_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in),
        .frame_mark(frame_mark), .frame_mode(frame_mode),
        .up_req(up_req), .dn_req(dn_req),
        .up_code(up_code), .up_len(up_len),
        .dn_code(dn_code), .dn_len(dn_len),
        .tx_bit(tx_bit)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: tx_bit=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // One strobe with the given data and marker, then check the output
    task automatic strobe(input logic d, input logic f, input logic exp, input string req);
        @(negedge clk);
        data_in = d; frame_mark = f; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        check(tx_bit, exp, req);
    endtask

    function automatic logic code_at(input logic [7:0] c, input logic [1:0] l, input int i);
        return c[7 - (i % (5 + int'(l)))];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; bit_en = 1'b1; data_in = 1'b1; frame_mark = 1'b0;
        frame_mode = 1'b0; up_req = 1'b0; dn_req = 1'b0;
        up_code = 8'h00; up_len = 2'd0; dn_code = 8'h00; dn_len = 2'd0;
        repeat (3) @(negedge clk);
        check(tx_bit, 1'b0, "R1 reset");
        bit_en = 1'b0; rst_n = 1'b1;
    endtask

    task automatic t_passthru();
        for (int i = 0; i < 12; i++) begin
            logic d = logic'((i * 7 + 3) % 5 > 1);
            strobe(d, logic'(i % 3 == 0), d, "R2 pass-through");
        end
    endtask

    task automatic t_hold();
        strobe(1'b1, 1'b0, 1'b1, "R2 pass-through");
        data_in = 1'b0;
        repeat (4) @(negedge clk);
        check(tx_bit, 1'b1, "R3 hold without strobe");
    endtask

    // Unframed up code at each length, frame marks ignored
    task automatic t_up_lengths();
        frame_mode = 1'b0;
        up_code = 8'b1011_0101;
        for (int l = 0; l < 4; l++) begin
            up_len = 2'(l);
            up_req = 1'b1;
            for (int i = 0; i < 17; i++)
                strobe(1'b0, logic'(i % 4 == 0), code_at(up_code, up_len, i),
                       l == 3 ? "R7 length 8" : "R4/R10 up code");
            up_req = 1'b0;
            strobe(1'b1, 1'b0, 1'b1, "R11 release");
        end
    endtask

    task automatic t_dn();
        dn_code = 8'b0110_1011; dn_len = 2'd2; dn_req = 1'b1;
        for (int i = 0; i < 15; i++)
            strobe(1'b1, 1'b0, code_at(dn_code, dn_len, i), "R5 down code");
        dn_req = 1'b0;
        strobe(1'b0, 1'b0, 1'b0, "R11 release");
    endtask

    task automatic t_both();
        up_code = 8'b1100_1000; up_len = 2'd0;
        dn_code = 8'b0011_0111; dn_len = 2'd3;
        up_req = 1'b1; dn_req = 1'b1;
        for (int i = 0; i < 11; i++)
            strobe(1'b0, 1'b0, code_at(up_code, up_len, i), "R6 up priority");
        up_req = 1'b0;
        for (int i = 0; i < 10; i++)
            strobe(1'b1, 1'b0, code_at(dn_code, dn_len, i), "R8 switch restarts");
        up_req = 1'b1;
        for (int i = 0; i < 3; i++)
            strobe(1'b0, 1'b0, code_at(up_code, up_len, i), "R8 switch restarts");
        up_req = 1'b0; dn_req = 1'b0;
        strobe(1'b1, 1'b0, 1'b1, "R11 release");
    endtask

    // Framed mode: every 4th bit is framing; code pauses there
    task automatic t_framed();
        int k = 0;
        frame_mode = 1'b1;
        up_code = 8'b1001_1100; up_len = 2'd1; up_req = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic f = logic'(i % 4 == 0);
            logic d = logic'(i % 8 == 0);
            if (f) strobe(d, 1'b1, d, "R9 framing bit passes");
            else begin
                strobe(d, 1'b0, code_at(up_code, up_len, k), "R9 code skips framing");
                k++;
            end
        end
        up_req = 1'b0;
        frame_mode = 1'b0;
        strobe(1'b0, 1'b0, 1'b0, "R11 release");
    endtask

    task automatic t_defaults();
        up_code = 8'b0000_1000; up_len = 2'd0; up_req = 1'b1;
        for (int i = 0; i < 10; i++)
            strobe(1'b1, 1'b0, logic'(i % 5 == 4), "R12 default up 00001");
        up_req = 1'b0;
        dn_code = 8'b0010_0100; dn_len = 2'd1; dn_req = 1'b1;
        for (int i = 0; i < 9; i++)
            strobe(1'b1, 1'b0, logic'(i % 3 == 2), "R12 default down 001");
        dn_req = 1'b0;
        strobe(1'b0, 1'b0, 1'b0, "R11 release");
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_passthru();
        t_hold();
        t_up_lengths();
        t_dn();
        t_both();
        t_framed();
        t_defaults();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule